// File: doc/BRIEF.md
# Serial Converter Interface Responder

This block is the digital side of a serial sampling converter, written as synthesizable logic. It serves as an emulation model or as a bus-functional responder on a board or in a simulation. A host pulls the active-low conversion-start line low. The block then captures a parallel sample and a two-bit sub-code and shifts them out MSB first on a serial data line. Each bit follows a rising edge of the serial clock. The data line has a separate output enable, so a pad or a resolver can float it while no frame is in progress.

The block also tracks a power state. The state is decided by how many serial clock rising edges fall between the start line going low and the start line going high again. After reset the block is uncalibrated. The first complete frame only calibrates it, and that frame's data is flagged as not valid. A frame that ends early enough puts the block into partial power-down. A later complete frame brings it back to normal operation. Release timing that the rules do not allow raises a one-cycle error pulse.

Both inputs are treated as synchronous to `clk` and are edge-detected against their values one clock earlier. Every reaction appears on the outputs one `clk` cycle after the edge is first sampled.

Top module: `scif_top`

## Requirements
- R1: A falling edge on `cnvst_n` while no frame is in progress captures `{sample, sub_bits}`, sets `dout_oe` to 1 and drives `dout` to 0. Later changes of `sample` do not alter the frame.
- R2: After the k-th rising edge of `sclk` in a frame, `dout` carries 0 for k < 4. For k = 4 to 13 it carries `sample[13-k]`, so the MSB comes first. For k = 14 it carries `sub_bits[1]` and for k = 15 `sub_bits[0]`. For k of 16 and above it carries 0.
- R3: A rising edge on `cnvst_n` clears `dout_oe`. If `cnvst_n` is still low after the 16th falling edge of `sclk`, the next `sclk` rising edge clears `dout_oe`, and it stays cleared until the next frame.
- R4: A frame that ends with a `cnvst_n` rise after 3 to 13 rising edges, from state normal (code 00) or partial power-down (code 01), leaves `pwr_state` at 01. The uncalibrated state never moves straight to 01.
- R5: A frame that ends after 14 or more rising edges sets `pwr_state` to 00 and `calibrated` to 1 from any state. `calibrated` never returns to 0 except through reset.
- R6: After reset, `pwr_state` is 10 (uncalibrated), `calibrated` is 0, and `dout_oe`, `data_valid` and `frame_err` are 0. At each frame start, `data_valid` takes the value `calibrated` had before that frame, so the calibrating frame reads as not valid.
- R7: A frame that ends after fewer than 3 rising edges, or an uncalibrated frame that ends after fewer than 14, pulses `frame_err` high for exactly one cycle and leaves `pwr_state` and `calibrated` unchanged.
- R8: A `sclk` rising edge sampled in the same cycle as the `cnvst_n` rise is counted as part of the frame before the frame is classified.
- R9: `sclk` edges while `cnvst_n` is high change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| cnvst_n | input | 1 | Active-low conversion start / frame enable |
| sclk | input | 1 | Serial clock from the host |
| sample | input | DATA_W | Parallel conversion result captured at frame start |
| sub_bits | input | SUB_W | Trailing sub-code shifted after the data |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Drive enable for `dout` (0 means high impedance) |
| pwr_state | output | 2 | 00 normal, 01 partial power-down, 10 uncalibrated |
| calibrated | output | 1 | Set by the first complete frame after reset |
| data_valid | output | 1 | Validity of the current or last frame's data |
| frame_err | output | 1 | One-cycle pulse for an illegal frame end |

## Verification
The delicate coincidence is a `sclk` rising edge and a `cnvst_n` rising edge in the same `clk` cycle. The single edge then both advances the count and ends the frame, so the classification boundary moves by one. The bench provokes this by raising both inputs together after 2 edges, 12 edges and 13 edges, and in random frames. It judges the outcome by the resulting `pwr_state`, `frame_err` and `dout_oe`, computed from the total edge count that includes the coincident edge. The release after the sixteenth falling edge is also raced against a late `cnvst_n` rise.

// File: rtl/scif_pkg.sv
package scif_pkg;

    // Power state code seen on the status port.
    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'b00,
        PWR_PARTIAL = 2'b01,
        PWR_UNCAL   = 2'b10
    } pwr_e;

    // Outcome of a frame when the start line returns high.
    typedef enum logic [1:0] {
        END_ABORT    = 2'b00,
        END_SLEEP    = 2'b01,
        END_COMPLETE = 2'b10
    } end_e;

    // Edge events of one sampled input.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Decide what a frame that ended after n rising edges means.
    function automatic end_e classify(input int n, input pwr_e st,
                                      input int lo, input int keep);
        if (n < lo)
            return END_ABORT;
        else if (n >= keep)
            return END_COMPLETE;
        else if (st == PWR_UNCAL)
            return END_ABORT;
        else
            return END_SLEEP;
    endfunction

endpackage

// File: rtl/scif_edge.sv
module scif_edge
    import scif_pkg::*;
#(
    parameter int          N    = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      din,
    output edge_t [N-1:0]     ev
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= IDLE;
        else
            prev_q <= din;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign ev[i].rise = din[i] & ~prev_q[i];
        assign ev[i].fall = ~din[i] & prev_q[i];
    end

endmodule

// File: rtl/scif_frame.sv
module scif_frame
    import scif_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SUB_W  = 2,
    parameter int LEAD_Z = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_t             cnv_ev,
    input  edge_t             sck_ev,
    input  logic [DATA_W-1:0] sample,
    input  logic [SUB_W-1:0]  sub_bits,
    output logic              dout,
    output logic              dout_oe,
    output logic              start,
    output logic              end_vld,
    output logic [CNT_W-1:0]  end_cnt
);

    localparam int WORD_W    = DATA_W + SUB_W;
    localparam int MSB_EDGE  = LEAD_Z + 1;
    localparam int LAST_EDGE = MSB_EDGE + WORD_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LAST_EDGE);

    logic              active;
    logic              done;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_inc;
    logic [WORD_W-1:0] cap;

    // Bit presented after the k-th rising edge.
    function automatic logic bit_at(input logic [CNT_W-1:0] k,
                                    input logic [WORD_W-1:0] w);
        int kk;
        kk = int'(k);
        if (kk >= MSB_EDGE && kk < LAST_EDGE)
            return w[LAST_EDGE - 1 - kk];
        else
            return 1'b0;
    endfunction

    assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    assign start   = ~active & cnv_ev.fall;
    assign end_vld = active & cnv_ev.rise;
    assign end_cnt = sck_ev.rise ? cnt_inc : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            done    <= 1'b0;
            dout_oe <= 1'b0;
            dout    <= 1'b0;
            cnt     <= '0;
            cap     <= '0;
        end else if (!active) begin
            if (cnv_ev.fall) begin
                active  <= 1'b1;
                done    <= 1'b0;
                dout_oe <= 1'b1;
                dout    <= 1'b0;
                cnt     <= '0;
                cap     <= {sample, sub_bits};
            end
        end else if (cnv_ev.rise) begin
            active  <= 1'b0;
            done    <= 1'b0;
            dout_oe <= 1'b0;
            dout    <= 1'b0;
        end else begin
            if (sck_ev.rise) begin
                cnt <= cnt_inc;
                if (done) begin
                    dout_oe <= 1'b0;
                    dout    <= 1'b0;
                end else begin
                    dout <= bit_at(cnt_inc, cap);
                end
            end
            if (sck_ev.fall && cnt >= LAST_C)
                done <= 1'b1;
        end
    end

endmodule

// File: rtl/scif_power.sv
module scif_power
    import scif_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int LO_EDGE = 3,
    parameter int KEEP    = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             end_vld,
    input  logic [CNT_W-1:0] end_cnt,
    output pwr_e             state,
    output logic             calibrated,
    output logic             data_valid,
    output logic             frame_err
);

    end_e verdict;

    assign verdict = classify(int'(end_cnt), state, LO_EDGE, KEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PWR_UNCAL;
            calibrated <= 1'b0;
            data_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            frame_err <= 1'b0;
            if (start)
                data_valid <= calibrated;
            if (end_vld) begin
                case (verdict)
                    END_ABORT:    frame_err <= 1'b1;
                    END_SLEEP:    state     <= PWR_PARTIAL;
                    END_COMPLETE: begin
                        state      <= PWR_NORMAL;
                        calibrated <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/scif_top.sv
module scif_top
    import scif_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SUB_W  = 2,
    parameter int LEAD_Z = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnvst_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample,
    input  logic [SUB_W-1:0]  sub_bits,
    output logic              dout,
    output logic              dout_oe,
    output logic [1:0]        pwr_state,
    output logic              calibrated,
    output logic              data_valid,
    output logic              frame_err
);

    localparam int LAST_EDGE = LEAD_Z + 1 + DATA_W + SUB_W;
    localparam int KEEP_EDGE = LEAD_Z + 1 + DATA_W;
    localparam int CNT_W     = $clog2(LAST_EDGE + 2) + 1;

    edge_t [1:0]      ev;
    logic             start;
    logic             end_vld;
    logic [CNT_W-1:0] end_cnt;
    pwr_e             state;

    // Bit 0: start line (idles high), bit 1: serial clock (idles low).
    scif_edge #(
        .N    (2),
        .IDLE (2'b01)
    ) u_edge (
        .clk (clk),
        .rst (rst),
        .din ({sclk, cnvst_n}),
        .ev  (ev)
    );

    scif_frame #(
        .DATA_W (DATA_W),
        .SUB_W  (SUB_W),
        .LEAD_Z (LEAD_Z),
        .CNT_W  (CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .cnv_ev   (ev[0]),
        .sck_ev   (ev[1]),
        .sample   (sample),
        .sub_bits (sub_bits),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .start    (start),
        .end_vld  (end_vld),
        .end_cnt  (end_cnt)
    );

    scif_power #(
        .CNT_W   (CNT_W),
        .LO_EDGE (LEAD_Z),
        .KEEP    (KEEP_EDGE)
    ) u_power (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .end_vld    (end_vld),
        .end_cnt    (end_cnt),
        .state      (state),
        .calibrated (calibrated),
        .data_valid (data_valid),
        .frame_err  (frame_err)
    );

    assign pwr_state = state;

endmodule

// File: rtl/scif_checker.sv
module scif_checker #(
    parameter int LEAD_Z = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       cnvst_n,
    input logic       sclk,
    input logic       dout,
    input logic       dout_oe,
    input logic [1:0] pwr_state,
    input logic       calibrated,
    input logic       frame_err
);

    localparam logic [7:0] MSB_EDGE = 8'(LEAD_Z + 1);

    logic       cnv_q;
    logic       sck_q;
    logic [7:0] rise_cnt;

    // Independent count of serial clock rises since the start line fell.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_q    <= 1'b1;
            sck_q    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            cnv_q <= cnvst_n;
            sck_q <= sclk;
            if (cnv_q && !cnvst_n)
                rise_cnt <= '0;
            else if (!cnvst_n && sclk && !sck_q && rise_cnt != 8'hFF)
                rise_cnt <= rise_cnt + 8'd1;
        end
    end

    assert_oe_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> $past(!cnvst_n));

    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && !cnvst_n && rise_cnt < MSB_EDGE) |-> !dout);

    assert_release_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(dout_oe) |-> ($past(cnvst_n) || $past(sclk)));

    assert_uncal_no_sleep_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(pwr_state) == 2'b10) |-> (pwr_state != 2'b01));

    assert_cal_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !$fell(calibrated));

    assert_code_legal_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_state != 2'b11);

    assert_err_needs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(cnvst_n));

    assert_err_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> ($stable(pwr_state) && $stable(calibrated)));

    assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

endmodule

bind scif_top scif_checker #(
    .LEAD_Z (LEAD_Z)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnvst_n    (cnvst_n),
    .sclk       (sclk),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .pwr_state  (pwr_state),
    .calibrated (calibrated),
    .frame_err  (frame_err)
);

// File: tb/scif_top_bench.sv
module scif_top_bench;

    localparam int DW = 10;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnvst_n = 1'b1;
    logic          sclk = 1'b0;
    logic [DW-1:0] sample = '0;
    logic [SW-1:0] sub_bits = '0;
    logic          dout;
    logic          dout_oe;
    logic [1:0]    pwr_state;
    logic          calibrated;
    logic          data_valid;
    logic          frame_err;

    int   checks = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    logic [1:0] m_state;
    bit   m_cal;

    scif_top u_scif_top (
        .clk        (clk),
        .rst        (rst),
        .cnvst_n    (cnvst_n),
        .sclk       (sclk),
        .sample     (sample),
        .sub_bits   (sub_bits),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .pwr_state  (pwr_state),
        .calibrated (calibrated),
        .data_valid (data_valid),
        .frame_err  (frame_err)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected serial bit after the k-th rising edge.
    function automatic bit exp_bit(input int k, input logic [DW-1:0] s, input logic [SW-1:0] sb);
        logic [DW+SW-1:0] w;
        w = {s, sb};
        if (k >= 4 && k <= 15)
            return w[15 - k];
        return 1'b0;
    endfunction

    // Run one frame of n rising edges; coinc raises both lines together on the last edge.
    task automatic frame(input logic [DW-1:0] s, input logic [SW-1:0] sb,
                         input int n, input bit coinc);
        bit exp_err;
        bit exp_valid;
        exp_valid = m_cal;
        sample   = s;
        sub_bits = sb;
        cnvst_n  = 1'b0;
        tick();
        chk("R1", "oe at start", dout_oe, 1);
        chk("R1", "dout at start", dout, 0);
        chk("R6", "data_valid", data_valid, exp_valid);
        sample   = ~s;
        sub_bits = ~sb;
        for (int k = 1; k <= n; k++) begin
            if (coinc && k == n) begin
                sclk    = 1'b1;
                cnvst_n = 1'b1;
                tick();
            end else begin
                sclk = 1'b1;
                tick();
                chk("R2", $sformatf("bit after edge %0d", k), dout, exp_bit(k, s, sb));
                chk("R3", $sformatf("oe after edge %0d", k), dout_oe, (k <= 16) ? 1 : 0);
                sclk = 1'b0;
                tick();
            end
        end
        if (!coinc) begin
            cnvst_n = 1'b1;
            tick();
        end
        // Model of the frame outcome.
        exp_err = 1'b0;
        if (n < 3)
            exp_err = 1'b1;
        else if (n >= 14) begin
            m_state = 2'b00;
            m_cal   = 1'b1;
        end else if (m_state == 2'b10)
            exp_err = 1'b1;
        else
            m_state = 2'b01;
        chk("R3", "oe after release", dout_oe, 0);
        chk(coinc ? "R8" : "R7", "frame_err", frame_err, exp_err);
        chk(coinc ? "R8" : "R4", "pwr_state", pwr_state, m_state);
        chk("R5", "calibrated", calibrated, m_cal);
        sclk = 1'b0;
        tick(2);
        chk("R7", "err pulse width", frame_err, 0);
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        m_state = 2'b10;
        m_cal   = 1'b0;
        tick(3);
        rst = 1'b0;
        tick();
        chk("R6", "reset state", pwr_state, 2);
        chk("R6", "reset cal", calibrated, 0);
        chk("R6", "reset oe", dout_oe, 0);
        chk("R6", "reset valid", data_valid, 0);
        chk("R6", "reset err", frame_err, 0);

        // Idle serial clock activity must change nothing.
        for (int i = 0; i < 6; i++) begin
            sclk = ~sclk;
            tick();
            chk("R9", "idle oe", dout_oe, 0);
            chk("R9", "idle state", pwr_state, 2);
            chk("R9", "idle err", frame_err, 0);
        end
        sclk = 1'b0;
        tick();

        frame(10'h2A5, 2'b10, 5, 1'b0);   // uncalibrated short frame: error
        frame(10'h3C1, 2'b01, 16, 1'b0);  // calibrating frame
        frame(10'h155, 2'b11, 16, 1'b0);  // first valid frame
        frame(10'h0F0, 2'b00, 8, 1'b0);   // into partial power-down
        frame(10'h333, 2'b10, 10, 1'b0);  // stays partial
        frame(10'h201, 2'b01, 14, 1'b0);  // back to normal
        frame(10'h1FF, 2'b11, 2, 1'b0);   // abort
        frame(10'h3FE, 2'b01, 19, 1'b0);  // release by serial clock after frame
        frame(10'h111, 2'b10, 3, 1'b1);   // coincident edge reaches 3
        frame(10'h222, 2'b01, 14, 1'b1);  // coincident edge reaches 14
        frame(10'h0AA, 2'b11, 13, 1'b1);  // coincident edge reaches 13
        frame(10'h055, 2'b00, 3, 1'b0);   // lower boundary from partial
        frame(10'h3AA, 2'b10, 17, 1'b1);  // coincident after full frame

        for (int i = 0; i < 60; i++) begin
            logic [DW-1:0] rs;
            logic [SW-1:0] rb;
            int rn;
            bit rc;
            rs = DW'($urandom());
            rb = SW'($urandom());
            rn = int'($urandom_range(0, 19));
            rc = (rn > 0) ? bit'($urandom_range(0, 1)) : 1'b0;
            frame(rs, rb, rn, rc);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule